// File: doc/BRIEF.md
# Trap condition evaluation unit

This unit decides whether a conditional-trap instruction takes its trap. Each cycle that `in_valid` is high it looks at a 32-bit instruction word, two 64-bit register operands and the address of the instruction. It recognises four trap forms: doubleword and word width, each with either a register or an immediate second operand. A 5-bit condition field in the instruction selects any set of signed, unsigned and equality comparisons of operand A against operand B. The trap fires when at least one selected comparison holds.

One clock after the strobe the unit returns its verdict. A fired trap raises a one-cycle trap request and presents the program-interrupt vector. It also reports the address of the trapping instruction as the address to resume from, and it sets a held trap-status flag for the interrupt logic to save. If the trap does not fire, the reported address is the next sequential instruction. The instruction has no other architectural effect, so the unit has no register-file write port. Operand fetch, interrupt entry and return from the handler belong to neighbouring logic.

Top module: `trap_unit`

## Requirements
- R1: The unit recognises four forms, with bit 0 the MSB of the 32-bit word. Primary opcode (bits 0–5 = `insn[31:26]`) 31 with extended opcode 68 in bits 21–30 (`insn[10:1]`) is doubleword register-register. Primary 31 with extended opcode 4 is word register-register. Primary 2 is doubleword immediate, and primary 3 is word immediate.
- R2: The condition field sits in bits 6–10 (`insn[25:21]`). Weight 16 selects signed A<B, 8 selects signed A>B, 4 selects A==B, 2 selects unsigned A<B and 1 selects unsigned A>B.
- R3: The trap fires when any selected comparison is true. A condition of 31 always fires, and a condition of 0 never fires.
- R4: Doubleword forms compare all 64 bits of the operands.
- R5: Word forms compare only the low 32 bits. These are sign-extended for the signed tests and zero-extended for the unsigned ones, and the upper operand bits have no effect.
- R6: Immediate forms take the 16-bit field in bits 16–31 (`insn[15:0]`), sign-extend it, and use it in place of `opb`. `opb` then has no effect.
- R7: `res_valid` is high exactly in the cycle after `in_valid`. `trap_req` is only ever high together with `res_valid`.
- R8: On a fired trap, `next_pc` equals the trapping instruction's `cia`, and `trap_vector` reads 0x700.
- R9: When no trap fires, `next_pc` equals `cia + 4` and `trap_vector` reads 0.
- R10: `trap_status` is loaded with the verdict of each recognised trap instruction and holds its value otherwise.
- R11: A word that is not one of the four forms raises no trap, leaves `trap_status` unchanged and yields `next_pc = cia + 4`.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Instruction presented this cycle |
| insn | input | 32 | Instruction word |
| opa | input | 64 | Operand A register value |
| opb | input | 64 | Operand B register value (ignored by immediate forms) |
| cia | input | 64 | Address of the presented instruction |
| res_valid | output | 1 | Verdict available (one cycle after `in_valid`) |
| trap_req | output | 1 | Program-interrupt request, one cycle |
| trap_status | output | 1 | Held flag: last recognised trap instruction fired |
| trap_vector | output | 64 | Interrupt vector while `trap_req` is high, else 0 |
| next_pc | output | 64 | Resume address: `cia` on trap, `cia + 4` otherwise |

## Verification
In a single cycle the unit can raise a trap request and also load the status flag from that verdict. In another cycle it can update the resume address while a non-trap word must leave the held flag alone. The bench provokes both cases. It sends a firing trap and checks the request, the vector, the flag and the unadvanced address together. It then sends an unrecognised word straight after and checks that the flag stays set while the address advances. The condition decision is judged on every mask value over boundary operand pairs in all four forms. Each expectation is formed from hand-derived comparison flags for that pair.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam int unsigned INSN_W = 32;
  localparam int unsigned COND_W = 5;
  localparam int unsigned IMM_W  = 16;

  localparam logic [5:0] OPC_EXT  = 6'd31;
  localparam logic [5:0] OPC_DIMM = 6'd2;
  localparam logic [5:0] OPC_WIMM = 6'd3;
  localparam logic [9:0] XO_DREG  = 10'd68;
  localparam logic [9:0] XO_WREG  = 10'd4;

  // Bit positions inside the condition field (weight 16 .. 1)
  localparam int unsigned CB_SLT = 4;
  localparam int unsigned CB_SGT = 3;
  localparam int unsigned CB_EQ  = 2;
  localparam int unsigned CB_ULT = 1;
  localparam int unsigned CB_UGT = 0;

  typedef enum logic [1:0] {
    FORM_DREG = 2'd0,
    FORM_WREG = 2'd1,
    FORM_DIMM = 2'd2,
    FORM_WIMM = 2'd3
  } trap_form_e;

  typedef struct packed {
    logic              hit;
    trap_form_e        form;
    logic [COND_W-1:0] cond;
    logic [IMM_W-1:0]  imm;
  } trap_dec_t;

endpackage

// File: rtl/trap_decode.sv
module trap_decode
  import trap_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output trap_dec_t         dec
);

  logic [5:0] opc;
  logic [9:0] xo;
  logic       unused_fields;

  assign opc = insn[31:26];
  assign xo  = insn[10:1];
  // Register selectors and the record bit are not needed for the verdict
  assign unused_fields = ^{insn[20:16], insn[0]};

  always_comb begin
    dec.hit  = 1'b0;
    dec.form = FORM_DREG;
    dec.cond = insn[25:21];
    dec.imm  = insn[15:0];
    if (opc == OPC_EXT && xo == XO_DREG) begin
      dec.hit  = 1'b1;
      dec.form = FORM_DREG;
    end else if (opc == OPC_EXT && xo == XO_WREG) begin
      dec.hit  = 1'b1;
      dec.form = FORM_WREG;
    end else if (opc == OPC_DIMM) begin
      dec.hit  = 1'b1;
      dec.form = FORM_DIMM;
    end else if (opc == OPC_WIMM) begin
      dec.hit  = 1'b1;
      dec.form = FORM_WIMM;
    end
  end

endmodule

// File: rtl/trap_operand.sv
module trap_operand #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IMMW  = 16
) (
  input  logic            is_word,
  input  logic            use_imm,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [IMMW-1:0] imm_i,
  output logic [XLEN-1:0] a_sx,
  output logic [XLEN-1:0] a_zx,
  output logic [XLEN-1:0] b_sx,
  output logic [XLEN-1:0] b_zx
);

  localparam int unsigned HALF = XLEN / 2;
  localparam int unsigned PADW = XLEN - IMMW;

  logic [XLEN-1:0] b_sel;

  assign b_sel = use_imm ? {{PADW{imm_i[IMMW-1]}}, imm_i} : b_i;

  always_comb begin
    if (is_word) begin
      a_sx = {{HALF{a_i[HALF-1]}},   a_i[HALF-1:0]};
      a_zx = {{HALF{1'b0}},          a_i[HALF-1:0]};
      b_sx = {{HALF{b_sel[HALF-1]}}, b_sel[HALF-1:0]};
      b_zx = {{HALF{1'b0}},          b_sel[HALF-1:0]};
    end else begin
      a_sx = a_i;
      a_zx = a_i;
      b_sx = b_sel;
      b_zx = b_sel;
    end
  end

endmodule

// File: rtl/trap_compare.sv
module trap_compare
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0]   a_sx,
  input  logic [XLEN-1:0]   a_zx,
  input  logic [XLEN-1:0]   b_sx,
  input  logic [XLEN-1:0]   b_zx,
  input  logic [COND_W-1:0] cond,
  output logic              fire
);

  logic [COND_W-1:0] rel;
  logic [COND_W-1:0] sel;

  always_comb begin
    rel         = '0;
    rel[CB_SLT] = $signed(a_sx) < $signed(b_sx);
    rel[CB_SGT] = $signed(a_sx) > $signed(b_sx);
    rel[CB_EQ]  = a_zx == b_zx;
    rel[CB_ULT] = a_zx < b_zx;
    rel[CB_UGT] = a_zx > b_zx;
  end

  for (genvar gi = 0; gi < COND_W; gi++) begin : g_sel
    assign sel[gi] = cond[gi] & rel[gi];
  end

  assign fire = |sel;

  // Signed and unsigned orderings come from separate comparators
  always_comb begin
    p_order_excl_r2: assert (!(rel[CB_SLT] && rel[CB_SGT]) && !(rel[CB_ULT] && rel[CB_UGT]));
    p_eq_excl_r2:    assert (!(rel[CB_EQ] && (rel[CB_SLT] || rel[CB_SGT] || rel[CB_ULT] || rel[CB_UGT])));
  end

endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int unsigned     XLEN    = 64,
  parameter int unsigned     PC_STEP = 4,
  parameter logic [XLEN-1:0] VECTOR  = 'h700
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] insn,
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   opb,
  input  logic [XLEN-1:0]   cia,
  output logic              res_valid,
  output logic              trap_req,
  output logic              trap_status,
  output logic [XLEN-1:0]   trap_vector,
  output logic [XLEN-1:0]   next_pc
);

  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // Decode and evaluate
  trap_dec_t       dec;
  logic            is_word;
  logic            use_imm;
  logic [XLEN-1:0] a_sx, a_zx, b_sx, b_zx;
  logic            fire;

  trap_decode u_decode (
    .insn (insn),
    .dec  (dec)
  );

  assign is_word = (dec.form == FORM_WREG) || (dec.form == FORM_WIMM);
  assign use_imm = (dec.form == FORM_DIMM) || (dec.form == FORM_WIMM);

  trap_operand #(.XLEN(XLEN), .IMMW(IMM_W)) u_operand (
    .is_word (is_word),
    .use_imm (use_imm),
    .a_i     (opa),
    .b_i     (opb),
    .imm_i   (dec.imm),
    .a_sx    (a_sx),
    .a_zx    (a_zx),
    .b_sx    (b_sx),
    .b_zx    (b_zx)
  );

  trap_compare #(.XLEN(XLEN)) u_compare (
    .a_sx (a_sx),
    .a_zx (a_zx),
    .b_sx (b_sx),
    .b_zx (b_zx),
    .cond (dec.cond),
    .fire (fire)
  );

  // Next-state
  logic            valid_d, req_d, stat_d, stat_en, pc_en;
  logic [XLEN-1:0] pc_d;
  logic            valid_q, req_q, stat_q;
  logic [XLEN-1:0] pc_q;

  always_comb begin
    valid_d = in_valid;
    req_d   = in_valid & dec.hit & fire;
    stat_en = in_valid & dec.hit;
    stat_d  = fire;
    pc_en   = in_valid;
    pc_d    = (dec.hit & fire) ? cia : cia + STEP;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      req_q   <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  stat_q <= 1'b0;
    else if (stat_en) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pc_q <= '0;
    else if (pc_en)  pc_q <= pc_d;
  end

  assign res_valid   = valid_q;
  assign trap_req    = req_q;
  assign trap_status = stat_q;
  assign next_pc     = pc_q;
  assign trap_vector = req_q ? VECTOR : '0;

  // Checks
  p_mask_zero_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && dec.hit && dec.cond == '0) |=> !trap_req);

  p_mask_all_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && dec.hit && dec.cond == '1) |=> trap_req);

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> res_valid);

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> (!res_valid && !trap_req));

  p_fault_pc_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_req |-> (next_pc == $past(cia)));

  p_seq_pc_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_valid && !trap_req) |-> (next_pc == $past(cia) + STEP));

  p_status_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_req |-> trap_status);

  p_nontrap_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !dec.hit) |=> (!trap_req && $stable(trap_status)));

endmodule

// File: tb/trap_unit_tb.sv
`timescale 1ns/1ps
module trap_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] insn;
  logic [63:0] opa, opb, cia;
  logic        res_valid, trap_req, trap_status;
  logic [63:0] trap_vector, next_pc;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  trap_unit u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .insn        (insn),
    .opa         (opa),
    .opb         (opb),
    .cia         (cia),
    .res_valid   (res_valid),
    .trap_req    (trap_req),
    .trap_status (trap_status),
    .trap_vector (trap_vector),
    .next_pc     (next_pc)
  );

  // form: 0 dword reg, 1 word reg, 2 dword imm, 3 word imm
  // flags {slt, sgt, eq, ult, ugt} derived by hand for each pair
  typedef struct packed {
    logic [1:0]  form;
    logic [63:0] a;
    logic [63:0] b;
    logic [15:0] imm;
    logic [4:0]  flags;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 64'h0, 64'h0, 16'h0, 5'b00100},
    '{2'd0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0, 5'b01010},
    '{2'd0, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 16'h0, 5'b10001},
    '{2'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 16'h0, 5'b01010},
    '{2'd0, 64'h5, 64'h7, 16'h0, 5'b10010},
    '{2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0, 5'b00100},
    '{2'd1, 64'hDEAD_BEEF_0000_0000, 64'h1234_5678_0000_0000, 16'h0, 5'b00100},
    '{2'd1, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_7FFF_FFFF, 16'h0, 5'b10001},
    '{2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 16'h0, 5'b10001},
    '{2'd1, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, 16'h0, 5'b10010},
    '{2'd2, 64'h0, 64'hA5A5_A5A5_A5A5_A5A5, 16'hFFFF, 5'b01010},
    '{2'd2, 64'hFFFF_FFFF_FFFF_8000, 64'h0, 16'h8000, 5'b00100},
    '{2'd2, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_8000, 16'h8000, 5'b01010},
    '{2'd2, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 16'h7FFF, 5'b10001},
    '{2'd3, 64'h1234_5678_FFFF_FFFF, 64'h0, 16'hFFFF, 5'b00100},
    '{2'd3, 64'hFFFF_FFFF_0000_7FFF, 64'h5A5A_5A5A_5A5A_5A5A, 16'h7FFF, 5'b00100},
    '{2'd3, 64'h0000_0000_0000_8000, 64'hFFFF_FFFF_FFFF_8000, 16'h8000, 5'b01010},
    '{2'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 16'h0001, 5'b10001}
  };

  function automatic logic [31:0] enc(input logic [1:0] f, input logic [4:0] c,
                                      input logic [15:0] imm);
    case (f)
      2'd0:    enc = {6'd31, c, 5'd3, 5'd4, 10'd68, 1'b0};
      2'd1:    enc = {6'd31, c, 5'd3, 5'd4, 10'd4, 1'b0};
      2'd2:    enc = {6'd2, c, 5'd3, imm};
      default: enc = {6'd3, c, 5'd3, imm};
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Present one word for one cycle; returns at the next falling edge,
  // after the result register has loaded.
  task automatic issue(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] pc);
    @(negedge clk);
    insn = w; opa = a; opb = b; cia = pc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; insn = '0; opa = '0; opb = '0; cia = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    check("R12 res_valid", 64'(res_valid), 64'd0);
    check("R12 trap_req", 64'(trap_req), 64'd0);
    check("R12 trap_status", 64'(trap_status), 64'd0);
    check("R12 next_pc", next_pc, 64'd0);
    check("R12 trap_vector", trap_vector, 64'd0);

    // R1 R2 R3 R4 R5 R6 R8 R9: every mask over each table row
    for (int v = 0; v < NV; v++) begin
      for (int m = 0; m < 32; m++) begin
        logic [63:0] pc;
        logic        exp_fire;
        pc       = 64'h1000 + 64'(v) * 64'h100 + 64'(m) * 64'd4;
        exp_fire = |(5'(m) & VECS[v].flags);
        issue(enc(VECS[v].form, 5'(m), VECS[v].imm), VECS[v].a, VECS[v].b, pc);
        check($sformatf("R3 fire row %0d mask %0d", v, m), 64'(trap_req), 64'(exp_fire));
        check($sformatf("R8/R9 next_pc row %0d mask %0d", v, m), next_pc,
              exp_fire ? pc : pc + 64'd4);
        check($sformatf("R8/R9 vector row %0d mask %0d", v, m), trap_vector,
              exp_fire ? 64'h700 : 64'h0);
        check($sformatf("R10 status row %0d mask %0d", v, m), 64'(trap_status), 64'(exp_fire));
      end
    end

    // R7: one-cycle verdict, then idle
    issue(enc(2'd0, 5'd31, 16'h0), 64'h1, 64'h2, 64'h2000);
    check("R7 res_valid after strobe", 64'(res_valid), 64'd1);
    check("R8 trap on all-ones mask", 64'(trap_req), 64'd1);
    check("R8 fault address", next_pc, 64'h2000);
    check("R10 status set", 64'(trap_status), 64'd1);
    @(negedge clk);
    check("R7 res_valid idle", 64'(res_valid), 64'd0);
    check("R7 trap_req idle", 64'(trap_req), 64'd0);
    check("R7 vector idle", trap_vector, 64'd0);

    // R11: unrecognised words straight after a fired trap
    issue({6'd14, 5'd31, 5'd3, 16'h0}, 64'h0, 64'h0, 64'h3000);
    check("R11 no trap other opcode", 64'(trap_req), 64'd0);
    check("R11 status held", 64'(trap_status), 64'd1);
    check("R11 next_pc", next_pc, 64'h3004);
    check("R7 res_valid non-trap word", 64'(res_valid), 64'd1);
    issue({6'd31, 5'd31, 5'd3, 5'd4, 10'd69, 1'b0}, 64'h0, 64'h0, 64'h3100);
    check("R11 no trap other extended opcode", 64'(trap_req), 64'd0);
    check("R11 status still held", 64'(trap_status), 64'd1);

    // R10: a non-firing trap instruction clears the flag
    issue(enc(2'd1, 5'd0, 16'h0), 64'h0, 64'h0, 64'h3200);
    check("R10 status cleared", 64'(trap_status), 64'd0);
    check("R3 zero mask no trap", 64'(trap_req), 64'd0);

    // R5 upper-half difference only: word eq, dword gt
    issue(enc(2'd1, 5'd4, 16'h0), 64'hFFFF_0000_0000_0009, 64'h0000_0000_0000_0009, 64'h3300);
    check("R5 word ignores upper half", 64'(trap_req), 64'd1);
    issue(enc(2'd0, 5'd4, 16'h0), 64'hFFFF_0000_0000_0009, 64'h0000_0000_0000_0009, 64'h3400);
    check("R4 dword sees upper half", 64'(trap_req), 64'd0);

    // R6: opb ignored by immediate form
    issue(enc(2'd2, 5'd4, 16'h0003), 64'h3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h3500);
    check("R6 immediate replaces opb", 64'(trap_req), 64'd1);

    finish_run();
  end

endmodule